// File: doc/BRIEF.md
# Bit-Serial Sorting Network

This block sorts a group of N unsigned words that enter side by side as N serial streams, one bit per clock per stream, most significant bit first. Each stage is a row of small compare-and-exchange cells. A cell watches its two bit streams. At the first bit where they differ, it fixes its routing as either straight through or crossed, and it keeps that routing for the rest of the word. A cell therefore needs only a couple of flip-flops and a few gates, where a parallel sorter would need a full-width magnitude comparator.

The stages form a bitonic sorting network. For N = 2^K there are K(K+1)/2 stages, and each stage adds one register of delay. A start flag marks the first (most significant) bit of every word group. The flag moves through the same register chain as the data, so each stage clears its cells exactly when its own copy of the next group arrives. The flag spacing alone sets the word length. Word groups may follow each other with no idle cycles, or with idle cycles between them whose bits are ignored.

Top module: `serial_sort_net`

## Requirements
- R1: During synchronous active-low reset, and on the first cycle after it, every serial output and the output start flag are 0.
- R2: The output start flag rises exactly L = K(K+1)/2 clocks after the input start flag, with N = 2^K. For the default N = 4, L = 3.
- R3: At every clock, the set of bits on the outputs is a permutation of the set of input bits from L clocks earlier, so the number of ones is kept.
- R4: The words are compared as unsigned numbers, with the first bit after the start flag being the most significant. Output lane 0 carries the smallest word and lane N-1 the largest, in non-decreasing order across the lanes.
- R5: Word groups that contain equal values come out with the duplicates on adjacent lanes and no value lost or changed.
- R6: The start flag clears every cell's routing decision. A group that follows another with no idle cycles is sorted without regard to the routing chosen for the previous group.
- R7: The word length is the spacing of the start flags. Any bits presented after a word has ended and before the next start flag do not affect the sorting of the next group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| serial_in | input | N | One serial bit per input lane, most significant bit first |
| word_start | input | 1 | High on the cycle that carries the first bit of a word group |
| serial_out | output | N | Sorted serial lanes, lane 0 smallest |
| out_word_start | output | 1 | High on the cycle that carries the first bit of a sorted group |

## Verification
The checker tests on every cycle the properties that hold bit by bit. Outputs stay quiet after reset. The start flag comes out after exactly L clocks. The number of ones passes through unchanged. Across the lanes, the bits already sent for a group never break ascending order, and this is tracked bit by bit while neighbouring lanes are still tied. Whole-word behaviour can only be shown by the bench's scenarios. These are the full sorted order of every possible group of four 3-bit words, the clearing of routing between groups sent back to back, and the immunity to bits sent in idle gaps with a different word length.

// File: rtl/serial_sort_pkg.sv
// Package: shared types and the functions that map a layer number onto the
// bitonic network geometry. Assumes the lane count is a power of two.
package serial_sort_pkg;

    // Routing of one compare-exchange cell.
    typedef enum logic {
        ROUTE_STRAIGHT = 1'b0,
        ROUTE_CROSS    = 1'b1
    } route_e;

    // Number of compare-exchange layers for 2**lg lanes.
    function automatic int num_layers(input int lg);
        return (lg * (lg + 1)) / 2;
    endfunction

    // Merge stage (block size 2**stage) that layer 'idx' belongs to.
    function automatic int layer_stage(input int lg, input int idx);
        int count;
        count = 0;
        for (int k = 1; k <= lg; k++) begin
            for (int j = k - 1; j >= 0; j--) begin
                if (count == idx) return k;
                count++;
            end
        end
        return lg;
    endfunction

    // Partner distance exponent (partner = lane ^ 2**sub) of layer 'idx'.
    function automatic int layer_sub(input int lg, input int idx);
        int count;
        count = 0;
        for (int k = 1; k <= lg; k++) begin
            for (int j = k - 1; j >= 0; j--) begin
                if (count == idx) return j;
                count++;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/ss_cx_cell.sv
// Module: one bit-serial compare-exchange cell.
// Passes a bit pair straight or crossed, registered. The routing is decided
// at the first bit of a word where the two streams differ, and it is held
// until the next start flag. DESC=0 puts the smaller word on 'lo'; DESC=1
// puts the larger word there.
// Assumes: MSB first; 'start' is high on the first bit of a word.
module ss_cx_cell
    import serial_sort_pkg::*;
#(
    parameter bit DESC = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic a,
    input  logic b,
    output logic lo,
    output logic hi
);

    logic   decided_q;
    route_e route_q;
    logic   differ;
    logic   want_cross;
    logic   open_now;
    route_e route_now;

    // Decide this cycle's routing from the held state or from the bit pair.
    always_comb begin
        differ     = a ^ b;
        want_cross = differ & (a ^ DESC);
        open_now   = start | ~decided_q;
        if (open_now) begin
            route_now = want_cross ? ROUTE_CROSS : ROUTE_STRAIGHT;
        end else begin
            route_now = route_q;
        end
    end

    // Hold the decision once the streams have differed within a word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            decided_q <= 1'b0;
            route_q   <= ROUTE_STRAIGHT;
        end else if (open_now) begin
            decided_q <= differ;
            route_q   <= route_now;
        end
    end

    // Register the routed bit pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo <= 1'b0;
            hi <= 1'b0;
        end else begin
            lo <= (route_now == ROUTE_CROSS) ? b : a;
            hi <= (route_now == ROUTE_CROSS) ? a : b;
        end
    end

endmodule

// File: rtl/ss_layer.sv
// Module: one layer of the bitonic network.
// It pairs lane i with lane i ^ 2**SUB. Pairs whose bit STAGE of the lower
// lane is set sort descending; all others sort ascending. It also delays the
// start flag by one register so that it stays level with the data.
// Assumes: N is a power of two, SUB < STAGE <= log2(N).
module ss_layer #(
    parameter int N     = 4,
    parameter int STAGE = 1,
    parameter int SUB   = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flag_in,
    input  logic [N-1:0] d_in,
    output logic         flag_out,
    output logic [N-1:0] d_out
);

    localparam int DIST = 1 << SUB;

    // Carry the start flag one stage forward.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_out <= 1'b0;
        else        flag_out <= flag_in;
    end

    for (genvar i = 0; i < N; i++) begin : g_lane
        if (((i >> SUB) & 1) == 0) begin : g_cell
            localparam bit DIR_DESC = (((i >> STAGE) & 1) == 1);
            ss_cx_cell #(
                .DESC (DIR_DESC)
            ) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .start (flag_in),
                .a     (d_in[i]),
                .b     (d_in[i + DIST]),
                .lo    (d_out[i]),
                .hi    (d_out[i + DIST])
            );
        end
    end

endmodule

// File: rtl/serial_sort_net.sv
// Module: bit-serial bitonic sorting network over N lanes (top).
// It chains num_layers(log2 N) layers. The latency from input to output is
// one clock per layer, for the data and the start flag alike. Lane 0 of the
// output carries the smallest word.
// Assumes: N is a power of two >= 2; the words are unsigned and sent MSB first.
module serial_sort_net
    import serial_sort_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] serial_in,
    input  logic         word_start,
    output logic [N-1:0] serial_out,
    output logic         out_word_start
);

    localparam int LG     = $clog2(N);
    localparam int LAYERS = num_layers(LG);

    logic [N-1:0] chain_d [0:LAYERS];
    logic         chain_f [0:LAYERS];

    // Feed the chain from the ports.
    always_comb begin
        chain_d[0] = serial_in;
        chain_f[0] = word_start;
    end

    for (genvar l = 0; l < LAYERS; l++) begin : g_layer
        localparam int STG = layer_stage(LG, l);
        localparam int SB  = layer_sub(LG, l);
        ss_layer #(
            .N     (N),
            .STAGE (STG),
            .SUB   (SB)
        ) u_layer (
            .clk      (clk),
            .rst_n    (rst_n),
            .flag_in  (chain_f[l]),
            .d_in     (chain_d[l]),
            .flag_out (chain_f[l+1]),
            .d_out    (chain_d[l+1])
        );
    end

    // Drive the ports from the last layer.
    always_comb begin
        serial_out     = chain_d[LAYERS];
        out_word_start = chain_f[LAYERS];
    end

endmodule

// File: rtl/serial_sort_net_chk.sv
// Module: assertion checker for serial_sort_net, attached with bind.
// It keeps its own delay lines for the start flag and the input bits, and
// it tracks per pair of adjacent output lanes whether their words are still
// tied within the current group.
module serial_sort_net_chk
    import serial_sort_pkg::*;
#(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] serial_in,
    input logic         word_start,
    input logic [N-1:0] serial_out,
    input logic         out_word_start
);

    localparam int LG     = $clog2(N);
    localparam int LAYERS = num_layers(LG);

    logic [LAYERS-1:0] flag_sr_q;
    logic [N-1:0]      data_sr_q [0:LAYERS-1];
    logic              was_reset_q;
    logic [N-2:0]      tied_q;

    // Remember whether the previous edge was in reset.
    always_ff @(posedge clk) was_reset_q <= !rst_n;

    // Delay lines matching the network latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_sr_q <= '0;
            for (int l = 0; l < LAYERS; l++) data_sr_q[l] <= '0;
        end else begin
            flag_sr_q <= {flag_sr_q[LAYERS-2:0], word_start};
            data_sr_q[0] <= serial_in;
            for (int l = 1; l < LAYERS; l++) data_sr_q[l] <= data_sr_q[l-1];
        end
    end

    // Track ties between neighbouring output words within a group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tied_q <= '0;
        end else begin
            for (int i = 0; i < N - 1; i++) begin
                if (out_word_start)
                    tied_q[i] <= (serial_out[i] == serial_out[i+1]);
                else
                    tied_q[i] <= tied_q[i] & (serial_out[i] == serial_out[i+1]);
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        was_reset_q |-> (serial_out == '0 && !out_word_start)); // R1

    AST_FLAG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_word_start == flag_sr_q[LAYERS-1]); // R2

    AST_ONES_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(serial_out) == $countones(data_sr_q[LAYERS-1])); // R3

    for (genvar i = 0; i < N - 1; i++) begin : g_ord
        AST_ASCENDING_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
            (out_word_start || tied_q[i]) |-> !(serial_out[i] && !serial_out[i+1])); // R4
    end

endmodule

bind serial_sort_net serial_sort_net_chk #(.N(N)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .serial_in      (serial_in),
    .word_start     (word_start),
    .serial_out     (serial_out),
    .out_word_start (out_word_start)
);

// File: tb/serial_sort_net_tb.sv
// Bench: first every group of four 3-bit words, sent back to back. Then
// pseudo-random 6-bit groups with forced duplicates, separated by idle
// cycles that carry junk bits.
module serial_sort_net_tb;

    localparam int N      = 4;
    localparam int K      = 2;
    localparam int L      = K * (K + 1) / 2;
    localparam int W1     = 3;
    localparam int W2     = 6;
    localparam int NRAND  = 300;
    localparam int NSETS  = 4096 + NRAND;

    logic         clk;
    logic         rst_n;
    logic [N-1:0] serial_in;
    logic         word_start;
    logic [N-1:0] serial_out;
    logic         out_word_start;

    int n_checks;
    int n_fail;
    int cyc;
    int cur_w;
    int n_sent;
    int n_recv;
    int drive_cyc;
    bit lat_checked;
    bit collecting;
    int bitpos;
    int sets_in [NSETS][N];
    logic [7:0] acc [N];

    serial_sort_net #(.N(N)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .serial_in      (serial_in),
        .word_start     (word_start),
        .serial_out     (serial_out),
        .out_word_start (out_word_start)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Compare one received group against the ascending sort of what was sent.
    task automatic check_group(input int idx, input int w);
        int exp_v [N];
        int tmp;
        bit bad;
        for (int i = 0; i < N; i++) exp_v[i] = sets_in[idx][i];
        for (int i = 1; i < N; i++) begin
            for (int j = i; j > 0; j--) begin
                if (exp_v[j-1] > exp_v[j]) begin
                    tmp = exp_v[j]; exp_v[j] = exp_v[j-1]; exp_v[j-1] = tmp;
                end
            end
        end
        bad = 0;
        for (int i = 0; i < N; i++) begin
            if (int'(acc[i] & ((8'd1 << w) - 8'd1)) != exp_v[i]) begin
                bad = 1;
                $display("FAIL R3/R4/R5/R6/R7 group %0d lane %0d: actual %0d expected %0d",
                         idx, i, acc[i] & ((8'd1 << w) - 8'd1), exp_v[i]);
            end
        end
        n_checks++;
        if (bad) n_fail++;
    endtask

    // Output monitor: collect each group's bits, and check the first latency.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_word_start) begin
                collecting = 1;
                bitpos = 0;
                if (!lat_checked) begin
                    lat_checked = 1;
                    n_checks++;
                    if (cyc - drive_cyc != L) begin
                        n_fail++;
                        $display("FAIL R2 latency: actual %0d expected %0d", cyc - drive_cyc, L);
                    end
                end
            end
            if (collecting) begin
                for (int i = 0; i < N; i++) acc[i] = {acc[i][6:0], serial_out[i]};
                bitpos++;
                if (bitpos == cur_w) begin
                    collecting = 0;
                    check_group(n_recv, cur_w);
                    n_recv++;
                end
            end
        end
    end

    // Send one group MSB first, followed by 'gap' idle cycles of junk.
    task automatic send_group(input int w, input int gap, input int junk);
        for (int b = w - 1; b >= 0; b--) begin
            @(negedge clk);
            if (n_sent == 0 && b == w - 1) drive_cyc = cyc;
            word_start = (b == w - 1);
            for (int i = 0; i < N; i++) serial_in[i] = sets_in[n_sent][i][b];
        end
        n_sent++;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            word_start = 1'b0;
            serial_in  = 4'(junk + g * 5);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int lfsr;
        n_checks = 0; n_fail = 0; cyc = 0; n_sent = 0; n_recv = 0;
        drive_cyc = 0; lat_checked = 0; collecting = 0; bitpos = 0;
        cur_w = W1;
        for (int i = 0; i < N; i++) acc[i] = '0;
        rst_n = 1'b0;
        serial_in = '1;
        word_start = 1'b1;
        // R1: outputs stay low while in reset, even with active inputs.
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            n_checks++;
            if (serial_out != '0 || out_word_start) begin
                n_fail++;
                $display("FAIL R1 reset: actual %b/%b expected 0000/0", serial_out, out_word_start);
            end
        end
        serial_in = '0;
        word_start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (serial_out != '0 || out_word_start) begin
            n_fail++;
            $display("FAIL R1 after reset: actual %b/%b expected 0000/0", serial_out, out_word_start);
        end

        // R4/R5/R6: every group of four 3-bit words, with no idle cycles.
        for (int s = 0; s < 4096; s++) begin
            for (int i = 0; i < N; i++) sets_in[s][i] = (s >> (3 * i)) & 7;
            send_group(W1, 0, 0);
        end
        @(negedge clk);
        word_start = 1'b0;
        serial_in = '0;
        while (n_recv != n_sent) @(negedge clk);

        // R7: 6-bit words with junk-filled gaps; R5: forced duplicates.
        cur_w = W2;
        lfsr = 32'h1ACE;
        for (int s = 0; s < NRAND; s++) begin
            for (int i = 0; i < N; i++) begin
                lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
                sets_in[4096 + s][i] = lfsr & 63;
            end
            if (s % 3 == 0) sets_in[4096 + s][1] = sets_in[4096 + s][3];
            if (s % 7 == 0) sets_in[4096 + s][0] = sets_in[4096 + s][2];
            send_group(W2, 1 + (s % 3), lfsr);
        end
        @(negedge clk);
        word_start = 1'b0;
        serial_in = '0;
        while (n_recv != n_sent) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule